// File: doc/BRIEF.md
# Programmable Eight-Source Interrupt Controller

This block collects eight interrupt request lines, decides which one deserves the processor's attention, and raises a single interrupt line toward the processor. When the processor acknowledges with two strobes, the block records the winning source as in service and returns an 8-bit type number made of a programmed base in the upper five bits and the source number in the lower three.

Software configures it through a byte-wide register port with one address bit. A start word opens a configuration sequence of two to four words whose length depends on bits of the start word. Only when that sequence completes does the block raise its interrupt line. After that, writes with the address bit high set the mask, and writes with it low issue end-of-service commands or choose which status register is read back. Requests can be taken on rising edges or as levels. Priority is fixed (source 0 first) until a rotating end-of-service command makes the serviced source the least favoured. An automatic mode ends service by itself at the second acknowledge strobe.

Top module: `irq_hub`

## Requirements
- R1: After reset the block is unconfigured: `irq_out` and `vec_valid` are low, and `irq_out` stays low whatever `irq_in` does until configuration completes.
- R2: A write with `addr_sel`=0 and `wdata[4]`=1 starts configuration: `wdata[0]`=1 asks for a fourth word, `wdata[1]`=1 means single (no third word), `wdata[3]`=1 selects level requests. The following writes with `addr_sel`=1 are taken, in order, as the base word, the third word (only when `wdata[1]` was 0) and the fourth word (only when `wdata[0]` was 1); the block is then ready and the next `addr_sel`=1 write loads the mask. The start word clears the mask, in-service and request registers.
- R3: On the second acknowledge strobe `vec_valid` is high for exactly one cycle, with `vec_out[7:3]` equal to bits 7..3 of the base word and `vec_out[2:0]` the serviced source number.
- R4: A mask bit of 1 keeps its source from raising `irq_out`; with `addr_sel`=1 `rdata` returns the mask.
- R5: With fixed priority, source 0 is most favoured and source 7 least; of several pending sources the most favoured is serviced.
- R6: `irq_out` is raised only for an unmasked pending source favoured over every in-service source; a less favoured request waits, a more favoured one raises `irq_out` while another is in service.
- R7: The first acknowledge strobe sets the winner's in-service bit and clears its request bit; `irq_out` is low between the two strobes.
- R8: In edge mode a request is latched on a 0-to-1 input transition, stays latched after the input falls, and an input held high does not request again after service.
- R9: In level mode the request bit follows the input; an input that falls before acknowledge withdraws its request.
- R10: A write with `addr_sel`=0, `wdata[4]`=0, `wdata[3]`=0 and `wdata[7:5]`=001 clears the most favoured in-service bit and leaves priority unchanged.
- R11: The same write with `wdata[7:5]`=101 clears the most favoured in-service bit and makes that source the least favoured, the next source number upward becoming the most favoured.
- R12: A write with `addr_sel`=0, `wdata[4]`=0, `wdata[3]`=1 and `wdata[1]`=1 selects the `addr_sel`=0 readback: `wdata[0]`=1 in-service register, 0 request register; the start word selects the request register.
- R13: With `wdata[1]`=1 in the fourth word, the in-service bit set by the first strobe is cleared at the second strobe.
- R14: A first strobe with no qualifying request yields a type number with low bits 7 and sets no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| addr_sel | input | 1 | Register select bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Readback: mask when `addr_sel`=1, else request or in-service register |
| irq_in | input | 8 | Interrupt request lines, synchronous to `clk` |
| irq_out | output | 1 | Interrupt to processor |
| ack | input | 1 | Acknowledge strobe, one cycle per pulse, two pulses per acknowledge |
| vec_out | output | 8 | Type number of the last acknowledge |
| vec_valid | output | 1 | High for one cycle when `vec_out` is fresh |

## Verification
A change on `irq_in` reaches the request register at the next rising edge, so `irq_out` is due one edge after the input moves; a register write likewise takes effect at the edge that samples the strobe, and `rdata` follows state combinationally. The type number is registered at the edge that samples the second strobe and holds `vec_valid` for that single cycle. The bench drives every input on the falling edge and reads every result on the following falling edge, which sits after exactly one rising edge, and it checks the withheld cases (masked, blocked, unconfigured, re-held level) at that same point.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_SLAVE,
    CFG_EXTRA,
    CFG_RUN
  } cfg_state_e;

  // bit positions in command bytes
  localparam int unsigned BIT_START  = 4;
  localparam int unsigned BIT_WANT4  = 0;
  localparam int unsigned BIT_SINGLE = 1;
  localparam int unsigned BIT_LEVEL  = 3;
  localparam int unsigned BIT_AUTO   = 1;
  localparam int unsigned BIT_SELCMD = 3;
  localparam int unsigned BIT_RDEN   = 1;
  localparam int unsigned BIT_RDISR  = 0;

  localparam logic [2:0] OP_EOI_PLAIN = 3'b001;
  localparam logic [2:0] OP_EOI_ROT   = 3'b101;

endpackage

// File: rtl/irq_hub_cfg.sv
module irq_hub_cfg
  import irq_hub_pkg::*;
#(
  parameter int unsigned N_IN = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  addr_sel,
  input  logic [N_IN-1:0]       wdata,
  output logic                  ready,
  output logic                  level_mode,
  output logic                  auto_end,
  output logic                  rd_isr,
  output logic [N_IN-$clog2(N_IN)-1:0] base,
  output logic [N_IN-1:0]       mask,
  output logic                  start_pulse,
  output logic                  eoi_pulse,
  output logic                  eoi_rotate
);

  localparam int unsigned IDW = $clog2(N_IN);
  localparam int unsigned BW  = N_IN - IDW;

  cfg_state_e       state_q, state_d;
  logic             want4_q, want4_d;
  logic             single_q, single_d;
  logic             level_q, level_d;
  logic             auto_q, auto_d;
  logic             rdisr_q, rdisr_d;
  logic [BW-1:0]    base_q, base_d;
  logic [N_IN-1:0]  mask_q, mask_d;

  logic wr_hi, wr_lo, is_start, is_cmd;
  logic unused_cfg;

  assign wr_hi    = wr_en &&  addr_sel;
  assign wr_lo    = wr_en && !addr_sel;
  assign is_start = wr_lo &&  wdata[BIT_START];
  assign is_cmd   = wr_lo && !wdata[BIT_START] && (state_q == CFG_RUN);

  assign start_pulse = is_start;
  assign eoi_pulse   = is_cmd && !wdata[BIT_SELCMD] &&
                       ((wdata[N_IN-1:N_IN-3] == OP_EOI_PLAIN) ||
                        (wdata[N_IN-1:N_IN-3] == OP_EOI_ROT));
  assign eoi_rotate  = wdata[N_IN-1];
  assign unused_cfg  = wdata[2];

  always_comb begin
    state_d  = state_q;
    want4_d  = want4_q;
    single_d = single_q;
    level_d  = level_q;
    auto_d   = auto_q;
    rdisr_d  = rdisr_q;
    base_d   = base_q;
    mask_d   = mask_q;
    if (is_start) begin
      state_d  = CFG_BASE;
      want4_d  = wdata[BIT_WANT4];
      single_d = wdata[BIT_SINGLE];
      level_d  = wdata[BIT_LEVEL];
      auto_d   = 1'b0;
      rdisr_d  = 1'b0;
      mask_d   = '0;
    end else begin
      if (is_cmd && wdata[BIT_SELCMD] && wdata[BIT_RDEN]) begin
        rdisr_d = wdata[BIT_RDISR];
      end
      if (wr_hi) begin
        unique case (state_q)
          CFG_BASE: begin
            base_d = wdata[N_IN-1:IDW];
            if (!single_q)    state_d = CFG_SLAVE;
            else if (want4_q) state_d = CFG_EXTRA;
            else              state_d = CFG_RUN;
          end
          CFG_SLAVE: begin
            state_d = want4_q ? CFG_EXTRA : CFG_RUN;
          end
          CFG_EXTRA: begin
            auto_d  = wdata[BIT_AUTO];
            state_d = CFG_RUN;
          end
          CFG_RUN:  mask_d = wdata;
          default:  state_d = state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= CFG_IDLE;
      want4_q  <= 1'b0;
      single_q <= 1'b1;
      level_q  <= 1'b0;
      auto_q   <= 1'b0;
      rdisr_q  <= 1'b0;
      base_q   <= '0;
      mask_q   <= '0;
    end else if (wr_en) begin
      state_q  <= state_d;
      want4_q  <= want4_d;
      single_q <= single_d;
      level_q  <= level_d;
      auto_q   <= auto_d;
      rdisr_q  <= rdisr_d;
      base_q   <= base_d;
      mask_q   <= mask_d;
    end
  end

  assign ready      = (state_q == CFG_RUN);
  assign level_mode = level_q;
  assign auto_end   = auto_q;
  assign rd_isr     = rdisr_q;
  assign base       = base_q;
  assign mask       = mask_q;

endmodule

// File: rtl/irq_hub_req.sv
module irq_hub_req #(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic            level_mode,
  input  logic            clr_all,
  input  logic [N_IN-1:0] clr_vec,
  output logic [N_IN-1:0] irr
);

  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] irr_q, irr_d;

  for (genvar g = 0; g < N_IN; g++) begin : g_src
    logic rise;
    assign rise = irq_in[g] && !prev_q[g];
    always_comb begin
      if (clr_all)         irr_d[g] = 1'b0;
      else if (level_mode) irr_d[g] = irq_in[g] && !clr_vec[g];
      else                 irr_d[g] = (irr_q[g] || rise) && !clr_vec[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      irr_q  <= irr_d;
    end
  end

  assign irr = irr_q;

endmodule

// File: rtl/irq_hub_rank.sv
module irq_hub_rank #(
  parameter int unsigned N_IN = 8
) (
  input  logic [N_IN-1:0]         req_vec,
  input  logic [N_IN-1:0]         isr_vec,
  input  logic [$clog2(N_IN)-1:0] low_id,
  output logic [$clog2(N_IN)-1:0] req_id,
  output logic [$clog2(N_IN)-1:0] isr_id,
  output logic                    isr_any,
  output logic                    req_wins
);

  localparam int unsigned IDW = $clog2(N_IN);

  logic [IDW-1:0] req_rank, isr_rank, idx;
  logic           req_any;

  // scan from least to most favoured so the most favoured hit sticks
  always_comb begin
    req_any  = 1'b0;
    isr_any  = 1'b0;
    req_id   = '0;
    isr_id   = '0;
    req_rank = '0;
    isr_rank = '0;
    idx      = '0;
    for (int k = N_IN - 1; k >= 0; k--) begin
      idx = low_id + IDW'(k + 1);
      if (req_vec[idx]) begin
        req_any  = 1'b1;
        req_id   = idx;
        req_rank = IDW'(k);
      end
      if (isr_vec[idx]) begin
        isr_any  = 1'b1;
        isr_id   = idx;
        isr_rank = IDW'(k);
      end
    end
    req_wins = req_any && (!isr_any || (req_rank < isr_rank));
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            addr_sel,
  input  logic [N_IN-1:0] wdata,
  output logic [N_IN-1:0] rdata,
  input  logic [N_IN-1:0] irq_in,
  output logic            irq_out,
  input  logic            ack,
  output logic [N_IN-1:0] vec_out,
  output logic            vec_valid
);

  localparam int unsigned IDW = $clog2(N_IN);
  localparam int unsigned BW  = N_IN - IDW;

  logic [1:0]      rst_sync_q;
  logic            rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic            cfg_ready, level_mode, auto_end, rd_isr;
  logic            start_pulse, eoi_pulse, eoi_rotate;
  logic [BW-1:0]   base;
  logic [N_IN-1:0] mask, irr, clr_vec;

  logic [N_IN-1:0] isr_q, isr_d;
  logic            phase_q, phase_d;
  logic [IDW-1:0]  low_q, low_d;
  logic [IDW-1:0]  svc_q, svc_d;
  logic            spur_q, spur_d;
  logic [N_IN-1:0] vec_q, vec_d;
  logic            vval_q, vval_d;

  logic [IDW-1:0]  req_id, isr_id;
  logic            isr_any, req_wins, req_hit, first_ack, second_ack;

  irq_hub_cfg #(.N_IN(N_IN)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_s),
    .wr_en       (wr_en),
    .addr_sel    (addr_sel),
    .wdata       (wdata),
    .ready       (cfg_ready),
    .level_mode  (level_mode),
    .auto_end    (auto_end),
    .rd_isr      (rd_isr),
    .base        (base),
    .mask        (mask),
    .start_pulse (start_pulse),
    .eoi_pulse   (eoi_pulse),
    .eoi_rotate  (eoi_rotate)
  );

  irq_hub_req #(.N_IN(N_IN)) u_req (
    .clk        (clk),
    .rst_n      (rst_s),
    .irq_in     (irq_in),
    .level_mode (level_mode),
    .clr_all    (start_pulse),
    .clr_vec    (clr_vec),
    .irr        (irr)
  );

  irq_hub_rank #(.N_IN(N_IN)) u_rank (
    .req_vec  (irr & ~mask),
    .isr_vec  (isr_q),
    .low_id   (low_q),
    .req_id   (req_id),
    .isr_id   (isr_id),
    .isr_any  (isr_any),
    .req_wins (req_wins)
  );

  assign req_hit    = cfg_ready && req_wins;
  assign first_ack  = ack && !phase_q;
  assign second_ack = ack &&  phase_q;

  always_comb begin
    clr_vec = '0;
    if (first_ack && req_hit) clr_vec[req_id] = 1'b1;
  end

  always_comb begin
    isr_d   = isr_q;
    phase_d = phase_q;
    low_d   = low_q;
    svc_d   = svc_q;
    spur_d  = spur_q;
    vec_d   = vec_q;
    vval_d  = 1'b0;
    if (start_pulse) begin
      isr_d   = '0;
      phase_d = 1'b0;
      low_d   = '1;
    end else begin
      if (eoi_pulse && isr_any) begin
        isr_d[isr_id] = 1'b0;
        if (eoi_rotate) low_d = isr_id;
      end
      if (first_ack) begin
        phase_d = 1'b1;
        if (req_hit) begin
          svc_d         = req_id;
          spur_d        = 1'b0;
          isr_d[req_id] = 1'b1;
        end else begin
          svc_d  = '1;
          spur_d = 1'b1;
        end
      end else if (second_ack) begin
        phase_d = 1'b0;
        vval_d  = 1'b1;
        vec_d   = {base, svc_q};
        if (auto_end && !spur_q) isr_d[svc_q] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      isr_q   <= '0;
      phase_q <= 1'b0;
      low_q   <= '1;
      svc_q   <= '0;
      spur_q  <= 1'b0;
      vec_q   <= '0;
      vval_q  <= 1'b0;
    end else begin
      isr_q   <= isr_d;
      phase_q <= phase_d;
      low_q   <= low_d;
      svc_q   <= svc_d;
      spur_q  <= spur_d;
      vec_q   <= vec_d;
      vval_q  <= vval_d;
    end
  end

  assign irq_out   = req_hit && !phase_q;
  assign vec_out   = vec_q;
  assign vec_valid = vval_q;
  assign rdata     = addr_sel ? mask : (rd_isr ? isr_q : irr);

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int unsigned N_IN = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        ack,
  input logic [N_IN-1:0]             irq_in,
  input logic                        irq_out,
  input logic [N_IN-1:0]             vec_out,
  input logic                        vec_valid,
  input logic                        cfg_ready,
  input logic [N_IN-$clog2(N_IN)-1:0] base,
  input logic [N_IN-1:0]             mask,
  input logic [N_IN-1:0]             irr,
  input logic [N_IN-1:0]             isr_q,
  input logic                        phase_q,
  input logic                        auto_end,
  input logic                        level_mode
);

  localparam int unsigned IDW = $clog2(N_IN);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ready |-> !irq_out);

  // R3
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(ack) && $past(phase_q)));

  // R3
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_out[N_IN-1:IDW] == base));

  // R4
  unmasked_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((irr & ~mask) != '0));

  // R7
  ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !phase_q && irq_out) |=> (isr_q != '0));

  // R7
  quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |-> !irq_out);

  // R13
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && auto_end) |-> !isr_q[vec_out[IDW-1:0]]);

  for (genvar g = 0; g < N_IN; g++) begin : g_edge
    // R8
    edge_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_mode && $rose(irr[g])) |-> $past(irq_in[g]));
  end

endmodule

bind irq_hub irq_hub_chk #(.N_IN(N_IN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack        (ack),
  .irq_in     (irq_in),
  .irq_out    (irq_out),
  .vec_out    (vec_out),
  .vec_valid  (vec_valid),
  .cfg_ready  (cfg_ready),
  .base       (base),
  .mask       (mask),
  .irr        (irr),
  .isr_q      (isr_q),
  .phase_q    (phase_q),
  .auto_end   (auto_end),
  .level_mode (level_mode)
);

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic       addr_sel;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [7:0] irq_in;
  logic       irq_out;
  logic       ack;
  logic [7:0] vec_out;
  logic       vec_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_hub u_irq_hub (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr_sel  (addr_sel),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq_in    (irq_in),
    .irq_out   (irq_out),
    .ack       (ack),
    .vec_out   (vec_out),
    .vec_valid (vec_valid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; addr_sel = 1'b0; wdata = '0; irq_in = '0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr_sel = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr_sel = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr_sel = a;
    #1;
    d = rdata;
    addr_sel = 1'b0;
  endtask

  task automatic drive_irq(input logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_reset_idle();
    do_reset();
    chk("R1 irq_out after reset", irq_out, 1'b0);
    chk("R1 vec_valid after reset", vec_valid, 1'b0);
    drive_irq(8'h08);
    repeat (2) @(negedge clk);
    chk("R1 irq_out unconfigured", irq_out, 1'b0);
  endtask

  task automatic t_basic_flow();
    logic [7:0] d;
    do_reset();
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h48);
    wr(1'b1, 8'hF0);
    rd(1'b1, d);
    chk("R2 short sequence then mask", d, 8'hF0);
    drive_irq(8'h20);
    chk("R4 masked source silent", irq_out, 1'b0);
    drive_irq(8'h26);
    chk("R5 unmasked request raises irq", irq_out, 1'b1);
    pulse_ack();
    rd(1'b0, d);
    chk("R7 request bit cleared", d, 8'h24);
    chk("R7 irq low between strobes", irq_out, 1'b0);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
    chk("R12 in-service readback", d, 8'h02);
    pulse_ack();
    chk("R3 vec_valid on second strobe", vec_valid, 1'b1);
    chk("R5 most favoured serviced", vec_out, 8'h49);
    @(negedge clk);
    chk("R3 vec_valid one cycle", vec_valid, 1'b0);
    chk("R6 less favoured blocked", irq_out, 1'b0);
    wr(1'b0, 8'h20);
    rd(1'b0, d);
    chk("R10 plain end clears in-service", d, 8'h00);
    chk("R10 pending source released", irq_out, 1'b1);
    wr(1'b0, 8'h0A);
    rd(1'b0, d);
    chk("R12 request readback", d, 8'h24);
  endtask

  task automatic t_level();
    do_reset();
    wr(1'b0, 8'h1A);
    wr(1'b1, 8'h08);
    drive_irq(8'h10);
    chk("R9 level request raises irq", irq_out, 1'b1);
    drive_irq(8'h00);
    chk("R9 level request withdrawn", irq_out, 1'b0);
  endtask

  task automatic t_edge();
    do_reset();
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h08);
    drive_irq(8'h10);
    drive_irq(8'h00);
    chk("R8 edge latched after fall", irq_out, 1'b1);
    pulse_ack();
    pulse_ack();
    chk("R8 edge vector", vec_out, 8'h0C);
    wr(1'b0, 8'h20);
    drive_irq(8'h10);
    chk("R8 new rise requests", irq_out, 1'b1);
    pulse_ack();
    pulse_ack();
    wr(1'b0, 8'h20);
    repeat (2) @(negedge clk);
    chk("R8 held input no repeat", irq_out, 1'b0);
  endtask

  task automatic t_long_auto();
    logic [7:0] d;
    do_reset();
    wr(1'b0, 8'h11);
    wr(1'b1, 8'hF0);
    wr(1'b1, 8'h0F);
    drive_irq(8'h01);
    chk("R2 not ready before fourth word", irq_out, 1'b0);
    wr(1'b1, 8'h03);
    chk("R2 ready after fourth word", irq_out, 1'b1);
    rd(1'b1, d);
    chk("R2 config words not taken as mask", d, 8'h00);
    pulse_ack();
    pulse_ack();
    chk("R3 base in vector", vec_out, 8'hF0);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
    chk("R13 auto end clears in-service", d, 8'h00);
  endtask

  task automatic t_rotate();
    logic [7:0] d;
    do_reset();
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h00);
    drive_irq(8'h01);
    pulse_ack();
    pulse_ack();
    chk("R5 source 0 vector", vec_out, 8'h00);
    drive_irq(8'h09);
    chk("R6 lower request waits", irq_out, 1'b0);
    wr(1'b0, 8'hA0);
    chk("R11 pending released after rotate", irq_out, 1'b1);
    drive_irq(8'h00);
    drive_irq(8'h09);
    pulse_ack();
    pulse_ack();
    chk("R11 rotated order favours 3 over 0", vec_out, 8'h03);
    drive_irq(8'h0B);
    chk("R6 favoured source preempts", irq_out, 1'b1);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
    chk("R11 in-service after rotation", d, 8'h08);
  endtask

  task automatic t_spurious();
    logic [7:0] d;
    do_reset();
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h48);
    pulse_ack();
    pulse_ack();
    chk("R14 spurious vector", vec_out, 8'h4F);
    wr(1'b0, 8'h0B);
    rd(1'b0, d);
    chk("R14 no in-service bit", d, 8'h00);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset_idle();
    t_basic_flow();
    t_level();
    t_edge();
    t_long_auto();
    t_rotate();
    t_spurious();
    summary();
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary();
  end

endmodule